// File: doc/BRIEF.md
# Denormalizing Mantissa Right Shifter

This block moves an extended-precision operand into denormal range. One operand is taken in each cycle that `in_valid` is high. The operand has a 15-bit biased exponent, a 64-bit mantissa and an 8-bit guard byte, and it comes with an unsigned 8-bit shift amount. The mantissa moves right by that amount and the exponent grows by the same amount. The bits that leave the mantissa are kept in a fresh guard byte, and the least significant bit of that byte doubles as a sticky flag for anything lost below it. The results are registered and appear one clock later, together with `out_valid`.

How the guard byte is filled depends on the shift amount. For short shifts the byte holds exactly the bits that left the mantissa. For longer shifts it holds the eight highest lost bits plus the sticky flag. For shifts past the whole mantissa-plus-guard width it reduces to a single nonzero flag. Whatever guard byte arrives at the input is never used. Rounding, exception reporting and the sign are left to neighbouring logic.

Top module: `mant_denorm`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. While `rst_n` is low, `out_valid` is held low.
- R2: `out_exp` equals `in_exp` plus `in_shift`, modulo 2^15.
- R3: For a shift amount below 72, `out_mant` equals `in_mant` shifted right logically by the amount. Amounts 64 to 71 therefore give zero.
- R4: For a shift amount n from 1 to 8, `out_guard[7:8-n]` holds `in_mant[n-1:0]` and the remaining lower guard bits are zero. No sticky bit is added.
- R5: For a shift amount of 0, `out_mant` equals `in_mant` and `out_guard` is zero.
- R6: For a shift amount n from 9 to 71, `out_guard` holds `in_mant[n-1:n-8]`, with positions above bit 63 read as zero. In addition, `out_guard[0]` is forced to 1 when any of `in_mant[n-9:0]` is 1.
- R7: For any shift amount from 72 to 255, `out_mant` is zero and `out_guard` is 8'h01 if `in_mant` was nonzero, otherwise 8'h00.
- R8: `in_guard` has no effect on any output, including the sticky bit.
- R9: In a cycle with `in_valid` low, `out_exp`, `out_mant` and `out_guard` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_exp | input | 15 | Biased exponent of the operand |
| in_mant | input | 64 | Mantissa of the operand |
| in_guard | input | 8 | Incoming guard byte (discarded) |
| in_shift | input | 8 | Right-shift amount |
| out_valid | output | 1 | Result present this cycle |
| out_exp | output | 15 | Exponent after denormalization |
| out_mant | output | 64 | Mantissa after the shift |
| out_guard | output | 8 | Lost bits with sticky in bit 0 |

## Verification
The bound checker watches every cycle for the following:
- the one-cycle valid timing;
- the exponent sum;
- the shifted mantissa for amounts below 72;
- the exact left-aligned capture for amounts 1 to 8;
- the zero-shift case;
- the saturated result from 72 upward;
- the outputs holding still while idle.

Several behaviours are shown only by the bench's scenarios. These are the guard byte with its sticky bit across amounts 9 to 71, and the fact that a changed input guard byte leaves every output unchanged. The bench covers every amount from 0 to 80 with random mantissas, and adds amounts at the top of the 8-bit range, a zero mantissa and exponent wraparound.

// File: rtl/dnz_pkg.sv
package dnz_pkg;
  parameter int EXP_W   = 15;
  parameter int MANT_W  = 64;
  parameter int GUARD_W = 8;
  parameter int CNT_W   = 8;

  // Shift amount beyond which every mantissa bit lands below the guard byte.
  localparam int SAT_LIMIT = MANT_W + GUARD_W;
  // Bits needed to hold 0..SAT_LIMIT; also the number of shifter stages.
  localparam int SAT_W     = $clog2(SAT_LIMIT + 1);
endpackage

// File: rtl/dnz_count_sat.sv
// Clamps the requested shift amount to the saturation limit so the shifter
// needs only as many stages as the limit requires.
module dnz_count_sat #(
  parameter int CNT_W = 8,
  parameter int SAT_W = 7,
  parameter int LIMIT = 72
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SAT_W-1:0] sat_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);
  localparam logic [SAT_W-1:0] LIMIT_S = SAT_W'(LIMIT);

  always_comb begin
    if (cnt_i >= LIMIT_C) begin
      sat_o = LIMIT_S;
    end else begin
      sat_o = SAT_W'(cnt_i);
    end
  end
endmodule

// File: rtl/dnz_shift_stage.sv
// One power-of-two step of the right shifter. The bits pushed off the low
// end of the window are folded into the running sticky flag.
module dnz_shift_stage #(
  parameter int WIDTH = 72,
  parameter int AMT   = 1
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] win_i,
  input  logic             sticky_i,
  output logic [WIDTH-1:0] win_o,
  output logic             sticky_o
);
  logic             lost_any;
  logic [WIDTH-1:0] shifted;

  assign lost_any = |win_i[AMT-1:0];
  assign shifted  = {{AMT{1'b0}}, win_i[WIDTH-1:AMT]};

  always_comb begin
    if (en_i) begin
      win_o    = shifted;
      sticky_o = sticky_i | lost_any;
    end else begin
      win_o    = win_i;
      sticky_o = sticky_i;
    end
  end
endmodule

// File: rtl/dnz_shifter.sv
// Logarithmic right shifter over a window made of the mantissa with a
// cleared guard byte beneath it. Sticky is gathered stage by stage.
module dnz_shifter #(
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int SAT_W   = 7
) (
  input  logic [MANT_W-1:0]  mant_i,
  input  logic [GUARD_W-1:0] guard_i,
  input  logic [SAT_W-1:0]   amt_i,
  output logic [MANT_W-1:0]  mant_o,
  output logic [GUARD_W-1:0] guard_o
);
  localparam int WIN_W = MANT_W + GUARD_W;
  // The incoming guard byte is masked off before the window is formed, so
  // neither the captured bits nor the sticky flag can see it.
  localparam logic [GUARD_W-1:0] GUARD_CLEAR = '0;

  logic [SAT_W:0][WIN_W-1:0] win;
  logic [SAT_W:0]            sticky;
  logic [WIN_W-1:0]          win_last;

  assign win[0]    = {mant_i, guard_i & GUARD_CLEAR};
  assign sticky[0] = 1'b0;

  for (genvar k = 0; k < SAT_W; k++) begin : g_stage
    dnz_shift_stage #(
      .WIDTH (WIN_W),
      .AMT   (1 << k)
    ) u_stage (
      .en_i     (amt_i[k]),
      .win_i    (win[k]),
      .sticky_i (sticky[k]),
      .win_o    (win[k+1]),
      .sticky_o (sticky[k+1])
    );
  end

  assign win_last = win[SAT_W];
  assign mant_o   = win_last[WIN_W-1:GUARD_W];
  assign guard_o  = win_last[GUARD_W-1:0] | {{(GUARD_W-1){1'b0}}, sticky[SAT_W]};
endmodule

// File: rtl/dnz_exp_add.sv
// Exponent adjust: adds the unclamped shift amount, wrapping at EXP_W bits.
module dnz_exp_add #(
  parameter int EXP_W = 15,
  parameter int CNT_W = 8
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [EXP_W-1:0] exp_o
);
  assign exp_o = exp_i + EXP_W'(cnt_i);
endmodule

// File: rtl/mant_denorm.sv
module mant_denorm #(
  parameter int EXP_W   = dnz_pkg::EXP_W,
  parameter int MANT_W  = dnz_pkg::MANT_W,
  parameter int GUARD_W = dnz_pkg::GUARD_W,
  parameter int CNT_W   = dnz_pkg::CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [EXP_W-1:0]   in_exp,
  input  logic [MANT_W-1:0]  in_mant,
  input  logic [GUARD_W-1:0] in_guard,
  input  logic [CNT_W-1:0]   in_shift,
  output logic               out_valid,
  output logic [EXP_W-1:0]   out_exp,
  output logic [MANT_W-1:0]  out_mant,
  output logic [GUARD_W-1:0] out_guard
);
  localparam int SAT_LIMIT = MANT_W + GUARD_W;
  localparam int SAT_W     = $clog2(SAT_LIMIT + 1);

  logic [SAT_W-1:0]   amt_sat;
  logic [EXP_W-1:0]   exp_d,   exp_q;
  logic [MANT_W-1:0]  mant_d,  mant_q;
  logic [GUARD_W-1:0] guard_d, guard_q;
  logic               vld_d,   vld_q;
  logic               load_en;

  dnz_count_sat #(
    .CNT_W (CNT_W),
    .SAT_W (SAT_W),
    .LIMIT (SAT_LIMIT)
  ) u_sat (
    .cnt_i (in_shift),
    .sat_o (amt_sat)
  );

  dnz_shifter #(
    .MANT_W  (MANT_W),
    .GUARD_W (GUARD_W),
    .SAT_W   (SAT_W)
  ) u_shift (
    .mant_i  (in_mant),
    .guard_i (in_guard),
    .amt_i   (amt_sat),
    .mant_o  (mant_d),
    .guard_o (guard_d)
  );

  dnz_exp_add #(
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) u_exp (
    .exp_i (in_exp),
    .cnt_i (in_shift),
    .exp_o (exp_d)
  );

  // Next-state: the valid flag follows the strobe; data loads only on strobe.
  always_comb begin
    vld_d   = in_valid;
    load_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      exp_q   <= exp_d;
      mant_q  <= mant_d;
      guard_q <= guard_d;
    end
  end

  assign out_valid = vld_q;
  assign out_exp   = exp_q;
  assign out_mant  = mant_q;
  assign out_guard = guard_q;
endmodule

// File: rtl/mant_denorm_chk.sv
module mant_denorm_chk #(
  parameter int EXP_W   = 15,
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [EXP_W-1:0]   in_exp,
  input logic [MANT_W-1:0]  in_mant,
  input logic [GUARD_W-1:0] in_guard,
  input logic [CNT_W-1:0]   in_shift,
  input logic               out_valid,
  input logic [EXP_W-1:0]   out_exp,
  input logic [MANT_W-1:0]  out_mant,
  input logic [GUARD_W-1:0] out_guard
);
  localparam int SAT_LIMIT = MANT_W + GUARD_W;
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT_LIMIT);
  localparam logic [CNT_W-1:0] GW_C  = CNT_W'(GUARD_W);

  logic seen_q;
  logic guard_unused;
  assign guard_unused = ^in_guard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (in_valid) seen_q <= 1'b1;
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_exp_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_exp == EXP_W'($past(in_exp) + EXP_W'($past(in_shift))));

  assert_mant_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shift < SAT_C) |=> out_mant == ($past(in_mant) >> $past(in_shift)));

  assert_small_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shift != '0 && in_shift <= GW_C)
      |=> out_guard == GUARD_W'($past(in_mant[GUARD_W-1:0]) << (GW_C - $past(in_shift))));

  assert_zero_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shift == '0) |=> (out_guard == '0 && out_mant == $past(in_mant)));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shift >= SAT_C)
      |=> (out_mant == '0 && out_guard == {{(GUARD_W-1){1'b0}}, $past(|in_mant)}));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && seen_q) |=> ($stable(out_exp) && $stable(out_mant) && $stable(out_guard)));
endmodule

bind mant_denorm mant_denorm_chk #(
  .EXP_W   (EXP_W),
  .MANT_W  (MANT_W),
  .GUARD_W (GUARD_W),
  .CNT_W   (CNT_W)
) u_chk (.*);

// File: tb/mant_denorm_bench.sv
module mant_denorm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [14:0] in_exp;
  logic [63:0] in_mant;
  logic [7:0]  in_guard;
  logic [7:0]  in_shift;
  logic        out_valid;
  logic [14:0] out_exp;
  logic [63:0] out_mant;
  logic [7:0]  out_guard;

  mant_denorm u_mant_denorm (
    .clk, .rst_n, .in_valid, .in_exp, .in_mant, .in_guard, .in_shift,
    .out_valid, .out_exp, .out_mant, .out_guard
  );

  typedef struct {
    logic [14:0] e;
    logic [63:0] m;
    logic [7:0]  g;
    string       gt;
    string       mt;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit have_last = 0;
  item_t last;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v,
                       input string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
    end
  endtask

  function automatic item_t model(input logic [14:0] e, input logic [63:0] m, input logic [7:0] c);
    logic [135:0] ext;
    int s;
    item_t r;
    s = (c >= 8'd72) ? 72 : int'(c);
    ext = {m, 72'b0} >> s;
    r.e = e + 15'(c);
    r.m = ext[135:72];
    r.g = ext[71:64];
    if (|ext[63:0]) r.g[0] = 1'b1;
    if (c == 0) r.gt = "R5";
    else if (c <= 8) r.gt = "R4";
    else if (c < 72) r.gt = "R6";
    else r.gt = "R7";
    r.mt = (c >= 8'd72) ? "R7" : "R3";
    return r;
  endfunction

  task automatic drive(input logic [14:0] e, input logic [63:0] m, input logic [7:0] g,
                       input logic [7:0] c, input string gtag = "");
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_exp = e; in_mant = m; in_guard = g; in_shift = c;
    it = model(e, m, c);
    if (gtag != "") it.gt = gtag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_guard = 8'($urandom);
    end
  endtask

  function automatic logic [63:0] rmant();
    return {32'($urandom), 32'($urandom)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            check("R1", 64'(out_valid), 64'd0, "unexpected out_valid");
          end else begin
            item_t it;
            it = sb.pop_front();
            check("R2", 64'(out_exp), 64'(it.e), "exponent");
            check(it.mt, out_mant, it.m, "mantissa");
            check(it.gt, 64'(out_guard), 64'(it.g), "guard");
            last = it;
            have_last = 1;
          end
        end else if (have_last) begin
          // R9: outputs hold while idle
          check("R9", out_mant, last.m, "held mantissa");
          check("R9", 64'(out_guard), 64'(last.g), "held guard");
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_exp = '0; in_mant = '0; in_guard = '0; in_shift = '0;
    repeat (3) @(negedge clk);
    check("R1", 64'(out_valid), 64'd0, "out_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 64'(out_valid), 64'd0, "out_valid after reset");

    // Sweep every amount 0..80 with random mantissas, back to back.
    for (int c = 0; c <= 80; c++) begin
      for (int k = 0; k < 3; k++) begin
        drive(15'($urandom), rmant() | 64'h8000_0000_0000_0000, 8'($urandom), 8'(c));
      end
    end
    idle(3);

    // Single-bit sticky probes for R6: only the lowest bit set.
    for (int c = 9; c < 72; c += 7) begin
      drive(15'h0100, 64'h1, 8'h00, 8'(c));
      idle(1);
    end

    // Saturation for R7 at the top of the range, and with a zero mantissa.
    drive(15'h1000, rmant(), 8'hAA, 8'd255);
    drive(15'h1000, 64'h0, 8'hFF, 8'd72);
    drive(15'h1000, 64'h1, 8'h00, 8'd128);
    drive(15'h1000, 64'h0, 8'hFF, 8'd200);
    idle(2);

    // R2: exponent wraps modulo 2^15.
    drive(15'h7FFF, rmant(), 8'h00, 8'd5);
    drive(15'h7F00, rmant(), 8'h00, 8'd255);
    idle(2);

    // R8: guard input must not leak, including into sticky (bit 0 set).
    for (int c = 0; c < 80; c += 5) begin
      logic [63:0] m;
      m = rmant();
      drive(15'h2000, m, 8'h00, 8'(c), "R8");
      drive(15'h2000, m, 8'hFF, 8'(c), "R8");
    end
    drive(15'h2000, 64'h0, 8'hFF, 8'd20, "R8");
    drive(15'h2000, 64'h0, 8'h01, 8'd3, "R8");

    // R9: long idle stretch with noisy inputs.
    @(negedge clk);
    in_valid = 1'b0; in_mant = rmant(); in_shift = 8'd17; in_exp = 15'h1234;
    idle(6);

    check("R1", 64'(sb.size()), 64'd0, "scoreboard drained");
    finish_run();
  end
endmodule